// File: doc/BRIEF.md
# Binary-Weighted Pulse-Rate DAC Core

This block models, in plain synchronous logic, a digital-to-analog scheme in which a number is represented by how many pulses arrive in a fixed window. A single free-running phase counter on the fast reference clock yields one pulse stream per input bit. The streams are binary weighted: each one runs at half the rate of the stream for the next more significant bit. Each bit of the held input word enables its own stream. The enabled streams are merged onto one pulse line, and the pulses in each sampling period are tallied.

The sampling period is 2^WIDTH reference cycles. At the end of each period the block presents the tally M together with a one-cycle strobe. Because of the stream construction, M equals the word that was held for that period exactly, so the output spans 2^WIDTH steps. A word written at any time waits in a pending register. It becomes active only at the boundary between two periods, so the pulse pattern never changes partway through a window. A downstream summing stage can turn the merged pulse line into a level.

Top module: `pdac_core`

## Requirements
- R1: While rst is high at a clock edge, the phase, the pending word, the active word and the tally are cleared. In the cycle after reset is released, pulse_out, count_valid and count_out are all 0. The first period after reset runs with an active word of 0.
- R2: count_valid is high for exactly one cycle in every 2^WIDTH cycles. The first strobe comes 2^WIDTH cycles after reset is released.
- R3: The count_out presented with each strobe equals the word that was active during the period that just ended. The value is an unsigned binary number of WIDTH bits.
- R4: Let p be the phase within the period, where the strobe cycle is phase 0. At p = 0, pulse_out is 0. At any other p, let k be the number of trailing zero bits of p. Then pulse_out equals bit WIDTH-1-k of the active word.
- R5: Binary weighting: word bit j produces exactly 2^j pulses per period, and no two streams pulse in the same cycle.
- R6: A word written during a period changes neither the pulses nor the count of that period. If no further write occurs, the active word stays the same from one period to the next.
- R7: When several writes land in one period, only the last one takes effect. A write in the final cycle of a period (phase 2^WIDTH-1) becomes active for the very next period.
- R8: count_out changes only in a strobe cycle and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write strobe for load_word |
| load_word | input | WIDTH | Word to convert; enters the pending register |
| pulse_out | output | 1 | Merged pulse line of all enabled streams |
| count_out | output | WIDTH | Pulse tally M of the last completed period |
| count_valid | output | 1 | One-cycle strobe marking a new count_out |

## Verification
The hardest case to reach is a write that arrives in the last cycle of a period. In that cycle, the new word must bypass the pending register and become active in the same edge. A close variant is two writes inside one period, where the second must replace the first without leaking into the pulses still being produced. The bench tracks the phase from the strobe. It sweeps every word value through back-to-back periods and compares each cycle's pulse against the trailing-zero rule. It then places writes at phase 0, at a mid phase and at the final phase, and checks the following period's pattern and count.

// File: rtl/pdac_pkg.sv
`timescale 1ns/1ps
package pdac_pkg;

    // Position of the reference phase within one sampling period.
    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,
        PH_RUN   = 2'd1,
        PH_CLOSE = 2'd2
    } phase_e;

    // Stream index that serves word bit bit_idx: the most significant bit
    // takes the fastest stream (index 0).
    function automatic int unsigned stream_for_bit(input int unsigned width,
                                                   input int unsigned bit_idx);
        return width - 1 - bit_idx;
    endfunction

    // Mask of the phase bits below stream index k.
    function automatic int unsigned below_mask(input int unsigned k);
        return (32'd1 << k) - 32'd1;
    endfunction

endpackage

// File: rtl/pdac_phase_ctr.sv
`timescale 1ns/1ps
module pdac_phase_ctr
    import pdac_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] phase,
    output phase_e           kind
);
    localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};

    logic [WIDTH-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        if (phase_q == LAST) begin
            kind = PH_CLOSE;
        end else if (phase_q == '0) begin
            kind = PH_OPEN;
        end else begin
            kind = PH_RUN;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/pdac_word_hold.sv
`timescale 1ns/1ps
module pdac_word_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic             swap,
    output logic [WIDTH-1:0] active
);
    logic [WIDTH-1:0] pending_q;
    logic [WIDTH-1:0] active_q;
    logic [WIDTH-1:0] pending_d;

    // A write in the swap cycle goes straight through to the active word.
    assign pending_d = load_en ? load_word : pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            pending_q <= pending_d;
            if (swap) begin
                active_q <= pending_d;
            end
        end
    end

    assign active = active_q;
endmodule

// File: rtl/pdac_stream_gate.sv
`timescale 1ns/1ps
module pdac_stream_gate
    import pdac_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] phase,
    input  logic [WIDTH-1:0] word,
    output logic             pulse
);
    logic [WIDTH-1:0] tone;
    logic [WIDTH-1:0] fire;

    for (genvar k = 0; k < WIDTH; k++) begin : g_stream
        localparam logic [WIDTH-1:0] LOW  = WIDTH'(below_mask(k));
        localparam int               BSEL = int'(stream_for_bit(WIDTH, k));
        // Stream k fires at odd multiples of 2^k: 2^(WIDTH-1-k) times per period.
        assign tone[k] = phase[k] && ((phase & LOW) == '0);
        assign fire[k] = tone[k] && word[BSEL];
    end

    assign pulse = |fire;
endmodule

// File: rtl/pdac_pulse_tally.sv
`timescale 1ns/1ps
module pdac_pulse_tally #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             close,
    output logic [WIDTH-1:0] acc,
    output logic [WIDTH-1:0] count,
    output logic             valid
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] count_q;
    logic             valid_q;
    logic [WIDTH-1:0] acc_next;

    assign acc_next = acc_q + {{(WIDTH-1){1'b0}}, pulse};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            count_q <= '0;
            valid_q <= 1'b0;
        end else if (close) begin
            acc_q   <= '0;
            count_q <= acc_next;
            valid_q <= 1'b1;
        end else begin
            acc_q   <= acc_next;
            valid_q <= 1'b0;
        end
    end

    assign acc   = acc_q;
    assign count = count_q;
    assign valid = valid_q;
endmodule

// File: rtl/pdac_core.sv
`timescale 1ns/1ps
module pdac_core
    import pdac_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    output logic             pulse_out,
    output logic [WIDTH-1:0] count_out,
    output logic             count_valid
);
    logic [WIDTH-1:0] phase;
    phase_e           kind;
    logic             period_close;
    logic [WIDTH-1:0] active_word;
    logic [WIDTH-1:0] tally_acc;
    logic             merged;

    assign period_close = (kind == PH_CLOSE);

    pdac_phase_ctr #(.WIDTH(WIDTH)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .kind  (kind)
    );

    pdac_word_hold #(.WIDTH(WIDTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_word (load_word),
        .swap      (period_close),
        .active    (active_word)
    );

    pdac_stream_gate #(.WIDTH(WIDTH)) u_gate (
        .phase (phase),
        .word  (active_word),
        .pulse (merged)
    );

    pdac_pulse_tally #(.WIDTH(WIDTH)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .pulse (merged),
        .close (period_close),
        .acc   (tally_acc),
        .count (count_out),
        .valid (count_valid)
    );

    assign pulse_out = merged;
endmodule

// File: rtl/pdac_core_chk.sv
`timescale 1ns/1ps
module pdac_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pulse_out,
    input logic [WIDTH-1:0] count_out,
    input logic             count_valid,
    input logic             period_close,
    input logic [WIDTH-1:0] active_word,
    input logic [WIDTH-1:0] tally_acc
);
    localparam logic [WIDTH:0] PERIOD = {1'b1, {WIDTH{1'b0}}};

    // Cycles since reset release or since the last strobe.
    logic [WIDTH:0] gap;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (count_valid) begin
            gap <= {{WIDTH{1'b0}}, 1'b1};
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_out == '0 && !count_valid && !pulse_out));

    // R2
    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        count_valid |-> (gap == PERIOD));

    a_r2_strobe_due: assert property (@(posedge clk) disable iff (rst)
        (gap == PERIOD) |-> count_valid);

    // R3: the running tally never passes the active word
    a_r3_tally_bound: assert property (@(posedge clk) disable iff (rst)
        tally_acc <= active_word);

    // R4: no pulse in the boundary cycle
    a_r4_quiet_boundary: assert property (@(posedge clk) disable iff (rst)
        count_valid |-> !pulse_out);

    // R6
    a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
        !period_close |=> $stable(active_word));

    // R8
    a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
        !count_valid |-> $stable(count_out));
endmodule

bind pdac_core pdac_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pulse_out    (pulse_out),
    .count_out    (count_out),
    .count_valid  (count_valid),
    .period_close (period_close),
    .active_word  (active_word),
    .tally_acc    (tally_acc)
);

// File: tb/pdac_core_test.sv
`timescale 1ns/1ps
module pdac_core_test;
    localparam int W = 4;
    localparam int PER = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic [W-1:0] load_word = '0;
    logic         pulse_out;
    logic [W-1:0] count_out;
    logic         count_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [W-1:0] last_count = '0;

    pdac_core #(.WIDTH(W)) uut (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_word   (load_word),
        .pulse_out   (pulse_out),
        .count_out   (count_out),
        .count_valid (count_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected pulse from the trailing-zero rule (R4).
    function automatic bit exp_pulse(input int p, input logic [W-1:0] w);
        int k = 0;
        if (p == 0) return 1'b0;
        while (((p >> k) & 1) == 0) k++;
        return w[W-1-k];
    endfunction

    // Entered at a negedge in phase 0. Checks one period against word cur and
    // drives up to two writes at the given phases.
    task automatic run_period(input logic [W-1:0] cur,
                              input bit do1, input int ph1, input logic [W-1:0] v1,
                              input bit do2, input int ph2, input logic [W-1:0] v2);
        int ones = 0;
        for (int p = 0; p < PER; p++) begin
            check(pulse_out == exp_pulse(p, cur), "R4 pulse pattern",
                  int'(pulse_out), int'(exp_pulse(p, cur)));
            if (pulse_out) ones++;
            if (p != 0) begin
                check(!count_valid, "R2 strobe width", int'(count_valid), 0);
                check(count_out == last_count, "R8 count hold",
                      int'(count_out), int'(last_count));
            end
            load_en = 1'b0;
            if (do1 && p == ph1) begin load_en = 1'b1; load_word = v1; end
            if (do2 && p == ph2) begin load_en = 1'b1; load_word = v2; end
            @(negedge clk);
        end
        load_en = 1'b0;
        check(ones == int'(cur), "R5 pulse total", ones, int'(cur));
        check(count_valid == 1'b1, "R2 strobe due", int'(count_valid), 1);
        check(count_out == cur, "R3 count equals word", int'(count_out), int'(cur));
        last_count = count_out;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] cur;
        repeat (3) @(negedge clk);
        check(count_out == '0, "R1 count after reset", int'(count_out), 0);
        check(!count_valid, "R1 strobe after reset", int'(count_valid), 0);
        check(!pulse_out, "R1 pulse after reset", int'(pulse_out), 0);
        rst = 1'b0;
        // First period runs with word 0; a write at phase 0 only takes effect next.
        run_period('0, 1'b1, 0, W'(1), 1'b0, 0, '0);
        cur = W'(1);
        // Sweep every word; each written in phase 0 of the period checking the previous (R6).
        for (int w = 2; w <= PER; w++) begin
            run_period(cur, 1'b1, 0, W'(w % PER), 1'b0, 0, '0);
            cur = W'(w % PER);
        end
        // R7: two writes in one period, the later one wins.
        run_period(cur, 1'b1, 0, W'(5), 1'b1, 9, W'(10));
        cur = W'(10);
        // R7: write in the final cycle is active in the next period.
        run_period(cur, 1'b1, PER - 1, W'(6), 1'b0, 0, '0);
        cur = W'(6);
        // R6: no write, word held.
        run_period(cur, 1'b0, 0, '0, 1'b0, 0, '0);
        // R5: one-hot words show per-bit weights.
        run_period(cur, 1'b1, 3, W'(8), 1'b0, 0, '0);
        run_period(W'(8), 1'b1, 2, W'(1), 1'b0, 0, '0);
        run_period(W'(1), 1'b1, 1, W'(15), 1'b0, 0, '0);
        run_period(W'(15), 1'b0, 0, '0, 1'b0, 0, '0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule